// File: doc/BRIEF.md
# FSK Carrier Detect Qualifier

This block decides whether a plausible FSK carrier is present on a telephone line receiver. It takes the sliced output of the band-pass filter, which is a one-bit zero-crossing signal, and measures the number of system clock cycles between its transitions. A transition counts as valid only when that interval falls inside a configured window, expressed in clock cycles, that matches the half-periods of the FSK tones. The carrier-detect output is active low. It falls after a configured run of consecutive valid intervals.

Once the block has locked, it stays locked through short dropouts. A hold-off counter is reloaded on every valid transition, and the block lets go of carrier-detect only when that counter runs out. With the default parameters this is 10 ms at a 10 MHz clock. While carrier-detect is inactive, the raw demodulated bit is replaced by a steady mark (logic 1). This keeps noise from reaching the downstream bit-timing recovery.

Power-down and a low enable both clear the qualification and force carrier-detect inactive.

Top module: `carrier_detect_qual`

## Requirements
- R1: After synchronous reset, `cd_n` is 1 (no carrier) and `gated_bit` is 1.
- R2: An interval between synchronized transitions of `zc_in` is valid only if it lies between `MIN_IVL` and `MAX_IVL` clock cycles, both bounds included. The first transition after reset, after power-down or after disable is never valid.
- R3: `cd_n` goes to 0 (carrier present) only once `QUAL_COUNT` consecutive valid intervals have been seen. It falls only in the cycle after a valid transition.
- R4: Before lock, any out-of-range interval clears the run of valid intervals, so a full new run of `QUAL_COUNT` is needed.
- R5: Once locked, `cd_n` stays 0 while fewer than `HOLD_CYCLES` cycles have passed since the last valid transition. Out-of-range transitions do not reload this window. `cd_n` returns to 1 once `HOLD_CYCLES` cycles pass with no valid transition.
- R6: `gated_bit` equals 1 whenever `cd_n` is 1, and equals `raw_bit` whenever `cd_n` is 0.
- R7: `pwr_dn` at 1 forces `cd_n` to 1 from the next cycle and discards all qualification progress. Lock must be rebuilt from scratch after `pwr_dn` returns to 0.
- R8: `en` at 0 has the same effect as `pwr_dn` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Block enable, active high |
| pwr_dn | input | 1 | Power-down request, active high |
| zc_in | input | 1 | Sliced band-filter output (asynchronous zero-crossing signal) |
| raw_bit | input | 1 | Raw demodulator output bit |
| cd_n | output | 1 | Carrier detect, active low |
| gated_bit | output | 1 | Demodulated bit passed to timing recovery, held at 1 without carrier |

## Verification
The bench builds the block with the following parameters:

| Parameter | Value |
|---|---|
| `MIN_IVL` | 20 cycles |
| `MAX_IVL` | 50 cycles |
| `QUAL_COUNT` | 4 |
| `HOLD_CYCLES` | 200 |

At these sizes, the following can be reached within a few hundred cycles:
- both window edges and their off-by-one neighbours (19, 20, 50 and 51 cycles);
- runs one interval short of locking;
- the expiry of the hold-off window.

The default values, a 10 ms hold-off and multi-thousand-cycle intervals, are far too long to exercise directly.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

    typedef enum logic {
        CDQ_HUNT = 1'b0,
        CDQ_LOCK = 1'b1
    } cdq_state_e;

    typedef struct packed {
        logic seen;   // synchronized transition this cycle
        logic valid;  // transition with an in-window interval
    } cdq_edge_t;

    function automatic logic in_window(input int unsigned ivl,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (ivl >= lo) && (ivl <= hi);
    endfunction

endpackage

// File: rtl/cdq_sync.sv
module cdq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d_in;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/cdq_interval_meter.sv
module cdq_interval_meter
    import cdq_pkg::*;
#(
    parameter int MIN_IVL = 2000,
    parameter int MAX_IVL = 5000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      zc_s,
    output cdq_edge_t ev
);
    localparam int W = $clog2(MAX_IVL + 2);
    localparam logic [W-1:0] SAT = W'(MAX_IVL + 1);

    logic         prev_q;
    logic [W-1:0] ivl_q;

    always_comb begin
        ev.seen  = zc_s ^ prev_q;
        ev.valid = ev.seen && !clr &&
                   in_window(32'(ivl_q), MIN_IVL, MAX_IVL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            ivl_q  <= SAT;
        end else begin
            prev_q <= zc_s;
            if (clr)
                ivl_q <= SAT;
            else if (ev.seen)
                ivl_q <= W'(1);
            else if (ivl_q != SAT)
                ivl_q <= ivl_q + W'(1);
        end
    end
endmodule

// File: rtl/cdq_qualifier.sv
module cdq_qualifier
    import cdq_pkg::*;
#(
    parameter int QUAL_COUNT  = 8,
    parameter int HOLD_CYCLES = 100000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  cdq_edge_t ev,
    output logic      locked
);
    localparam int CW = $clog2(QUAL_COUNT + 1);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST_RUN = CW'(QUAL_COUNT - 1);
    localparam logic [HW-1:0] HOLD_LD  = HW'(HOLD_CYCLES);

    cdq_state_e    state_q;
    logic [CW-1:0] run_q;
    logic [HW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= CDQ_HUNT;
            run_q   <= '0;
            hold_q  <= '0;
        end else begin
            unique case (state_q)
                CDQ_HUNT: begin
                    if (ev.seen) begin
                        if (!ev.valid) begin
                            run_q <= '0;
                        end else if (run_q == LAST_RUN) begin
                            state_q <= CDQ_LOCK;
                            run_q   <= '0;
                            hold_q  <= HOLD_LD;
                        end else begin
                            run_q <= run_q + CW'(1);
                        end
                    end
                end
                CDQ_LOCK: begin
                    if (ev.valid) begin
                        hold_q <= HOLD_LD;
                    end else if (hold_q <= HW'(1)) begin
                        state_q <= CDQ_HUNT;
                        hold_q  <= '0;
                    end else begin
                        hold_q <= hold_q - HW'(1);
                    end
                end
                default: state_q <= CDQ_HUNT;
            endcase
        end
    end

    assign locked = (state_q == CDQ_LOCK);
endmodule

// File: rtl/carrier_detect_qual.sv
module carrier_detect_qual
    import cdq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_IVL     = 2000,
    parameter int MAX_IVL     = 5000,
    parameter int QUAL_COUNT  = 8,
    parameter int HOLD_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic pwr_dn,
    input  logic zc_in,
    input  logic raw_bit,
    output logic cd_n,
    output logic gated_bit
);
    logic      zc_s;
    logic      clr;
    logic      locked;
    cdq_edge_t ev;

    assign clr = pwr_dn || !en;

    cdq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_in(zc_in), .d_out(zc_s)
    );

    cdq_interval_meter #(.MIN_IVL(MIN_IVL), .MAX_IVL(MAX_IVL)) u_meter (
        .clk(clk), .rst(rst), .clr(clr), .zc_s(zc_s), .ev(ev)
    );

    cdq_qualifier #(.QUAL_COUNT(QUAL_COUNT), .HOLD_CYCLES(HOLD_CYCLES)) u_qual (
        .clk(clk), .rst(rst), .clr(clr), .ev(ev), .locked(locked)
    );

    assign cd_n      = !locked;
    assign gated_bit = locked ? raw_bit : 1'b1;
endmodule

// File: rtl/cdq_checker.sv
module cdq_checker #(
    parameter int HOLD_CYCLES = 100000
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic pwr_dn,
    input logic edge_valid,
    input logic cd_n,
    input logic gated_bit
);
    localparam int QW = $clog2(HOLD_CYCLES + 1);
    logic [QW-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst || edge_valid) quiet_q <= '0;
        else if (quiet_q != QW'(HOLD_CYCLES)) quiet_q <= quiet_q + QW'(1);
    end

    // R7
    pwr_dn_release_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> cd_n);

    // R8
    disable_release_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> cd_n);

    // R6
    gate_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cd_n |-> gated_bit);

    // R3
    lock_on_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cd_n) |-> $past(edge_valid));

    // R5
    hold_window_chk: assert property (@(posedge clk) disable iff (rst)
        (!cd_n && en && !pwr_dn && (edge_valid || quiet_q < QW'(HOLD_CYCLES - 1)))
        |=> !cd_n);
endmodule

bind carrier_detect_qual cdq_checker #(.HOLD_CYCLES(HOLD_CYCLES)) chk_i (
    .clk(clk), .rst(rst), .en(en), .pwr_dn(pwr_dn),
    .edge_valid(ev.valid), .cd_n(cd_n), .gated_bit(gated_bit)
);

// File: tb/carrier_detect_qual_tb_top.sv
module carrier_detect_qual_tb_top;
    localparam int MIN_IVL = 20;
    localparam int MAX_IVL = 50;
    localparam int QUAL    = 4;
    localparam int HOLD    = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b1;
    logic pwr_dn = 1'b0;
    logic zc_in = 1'b0;
    logic raw_bit = 1'b0;
    logic cd_n;
    logic gated_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    carrier_detect_qual #(
        .SYNC_STAGES(2), .MIN_IVL(MIN_IVL), .MAX_IVL(MAX_IVL),
        .QUAL_COUNT(QUAL), .HOLD_CYCLES(HOLD)
    ) dut_i (
        .clk(clk), .rst(rst), .en(en), .pwr_dn(pwr_dn), .zc_in(zc_in),
        .raw_bit(raw_bit), .cd_n(cd_n), .gated_bit(gated_bit)
    );

    // {interval, number of flips, expected cd_n}
    localparam int VEC [8][3] = '{
        '{30, 4, 1},   // R3 one interval short
        '{30, 5, 0},   // R3 exact run
        '{10, 10, 1},  // R2 too fast
        '{60, 10, 1},  // R2 too slow
        '{20, 5, 0},   // R2 lower bound
        '{50, 5, 0},   // R2 upper bound
        '{19, 8, 1},   // R2 below lower bound
        '{51, 8, 1}    // R2 above upper bound
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic flip_after(input int d);
        wait_cyc(d);
        zc_in = ~zc_in;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b1; pwr_dn = 1'b0;
        wait_cyc(3);
        rst = 1'b0;
    endtask

    // first flip is never valid, then QUAL valid intervals of 30
    task automatic lock_up();
        flip_after(1);
        repeat (QUAL) flip_after(30);
        wait_cyc(4);
    endtask

    initial begin
        do_reset();
        // R1
        check("R1 cd_n after reset", cd_n, 1'b1);
        check("R1 gated_bit after reset", gated_bit, 1'b1);

        for (int v = 0; v < 8; v++) begin
            do_reset();
            flip_after(1);
            for (int k = 1; k < VEC[v][1]; k++) flip_after(VEC[v][0]);
            wait_cyc(4);
            check($sformatf("R2/R3 vector %0d", v), cd_n, VEC[v][2] != 0);
        end

        // R4: bad interval in the middle of a run
        do_reset();
        flip_after(1);
        repeat (3) flip_after(30);
        flip_after(10);
        repeat (3) flip_after(30);
        wait_cyc(4);
        check("R4 run cleared by short interval", cd_n, 1'b1);
        flip_after(26);
        wait_cyc(4);
        check("R4 fresh run locks", cd_n, 1'b0);

        // R6 gating
        do_reset();
        raw_bit = 1'b0;
        wait_cyc(2);
        check("R6 gated high without carrier", gated_bit, 1'b1);
        lock_up();
        raw_bit = 1'b0; wait_cyc(1);
        check("R6 gated follows raw 0", gated_bit, 1'b0);
        raw_bit = 1'b1; wait_cyc(1);
        check("R6 gated follows raw 1", gated_bit, 1'b1);
        raw_bit = 1'b0;

        // R5 hold-off expiry: last flip 4 cycles ago
        wait_cyc(HOLD - 14);
        check("R5 held before window ends", cd_n, 1'b0);
        wait_cyc(20);
        check("R5 released after window", cd_n, 1'b1);
        check("R6 gated high after release", gated_bit, 1'b1);

        // R5 dropout shorter than window, then resume
        do_reset();
        lock_up();
        flip_after(146);          // interval 150: out of range, no reload
        check("R5 held over dropout", cd_n, 1'b0);
        flip_after(30);
        flip_after(30);
        wait_cyc(HOLD - 20);
        check("R5 valid edge reloaded window", cd_n, 1'b0);
        wait_cyc(30);
        check("R5 released after resumed burst", cd_n, 1'b1);

        // R7 power-down
        do_reset();
        lock_up();
        check("R7 locked before power-down", cd_n, 1'b0);
        pwr_dn = 1'b1;
        wait_cyc(1);
        check("R7 cd_n high in power-down", cd_n, 1'b1);
        wait_cyc(3);
        pwr_dn = 1'b0;
        flip_after(1);
        repeat (QUAL - 1) flip_after(30);
        wait_cyc(4);
        check("R7 progress discarded", cd_n, 1'b1);
        flip_after(26);
        wait_cyc(4);
        check("R7 relocks after full run", cd_n, 1'b0);

        // R8 enable low
        en = 1'b0;
        wait_cyc(1);
        check("R8 cd_n high when disabled", cd_n, 1'b1);
        flip_after(26);
        flip_after(30);
        wait_cyc(2);
        check("R8 edges ignored while disabled", cd_n, 1'b1);
        en = 1'b1;
        wait_cyc(2);
        check("R8 no lock right after enable", cd_n, 1'b1);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule